// File: doc/BRIEF.md
# Address-Steered Store-and-Forward Packet Router

This block takes a stream of byte-wide packets on a single input and delivers each one to one of several byte-wide output ports. Every packet starts with a two-byte header. The first header byte is the destination address and the second carries the payload length. The payload bytes follow, and a single check byte closes the packet. A controller state machine follows this framing one accepted byte per clock. It compares the destination address against a programmable address for each output port. It then writes the whole packet into the buffer of the matching port, check byte included.

The check byte is verified while the packet streams in, and a mismatch produces a one-cycle error pulse. A packet whose address matches no port is read through its full length and dropped. When the buffer a packet is headed for has no room, the router raises a hold signal toward the sender, and the sender keeps the current byte on the input until the hold clears. Each output port presents its oldest byte with a valid flag. The consumer removes that byte with its own read-enable.

Top module: `pkt_router`

## Requirements
- R1: After reset every output-valid flag is low, the error flag is low, the hold signal is low while the buffers are empty, and the next accepted byte is taken as a destination address.
- R2: Every byte of a routed packet appears, in arrival order, at the selected output port: address byte, length byte, payload bytes, check byte. Each byte is unchanged.
- R3: A packet is written only into the buffer of the port whose 8-bit address equals the destination byte. No other port's buffer gains any byte.
- R4: A packet whose destination byte matches no port address is consumed over its full framed length and written nowhere. The byte after its check byte is parsed as a new destination address.
- R5: The payload length is the low 6 bits of the length byte (0 to 63). The upper 2 bits do not change the framing, and the length byte is still stored as received.
- R6: The error flag is high for exactly the one cycle after the check byte is accepted, and only when that byte differs from the bitwise XOR of the address byte, the length byte and all payload bytes.
- R7: The hold signal is high whenever the buffer of the packet's target port is full. In the address state, the target is the port matching the byte on the input. A byte offered while the hold signal is high is not accepted, and no buffer ever overflows.
- R8: An output-valid flag is high exactly when that port's buffer is non-empty, with the oldest byte on that port's data lane. A read-enable while valid removes one byte. A read-enable on an empty port has no effect.
- R9: If several ports carry the same address, the lowest-numbered of them receives the packet.
- R10: A length of zero frames a three-byte packet (address, length, check), and the check byte is the XOR of the two header bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sender offers `in_data` this cycle |
| in_data | input | 8 | Incoming packet byte |
| port_addr | input | NPORTS*8 | Address of each port; port i in bits [8i+7:8i] |
| suspend | output | 1 | Hold request: the offered byte is not accepted |
| err | output | 1 | One-cycle pulse on a check-byte mismatch |
| rd_en | input | NPORTS | Per-port read-enable, pops the head byte |
| out_valid | output | NPORTS | Per-port buffer non-empty |
| out_data | output | NPORTS*8 | Per-port head byte; port i in bits [8i+7:8i] |

## Verification
The bench builds the router with four ports and a buffer depth of 8. That depth lets a single payload of a few bytes fill a buffer completely. This brings the hold signal within reach in two places: in the middle of a packet, and against a fresh address byte aimed at an already-full port. The length width stays at 6, so length bytes with the upper two bits set exercise the masking. Port addresses are changed between packets to create a duplicate address, which reaches the lowest-index priority.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_LEN  = 2'd1,
    ST_BODY = 2'd2,
    ST_CHK  = 2'd3
  } rtr_state_e;

  // running check value: fold one more byte into the accumulator
  function automatic byte_t chk_fold(input byte_t acc_v, input byte_t b);
    return acc_v ^ b;
  endfunction

  // keep the lowest set bit of a request vector
  function automatic logic [31:0] lowest_bit(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/rtr_addr_match.sv
module rtr_addr_match
  import rtr_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  byte_t                    addr,
  input  logic [NPORTS*BYTE_W-1:0] port_addr,
  output logic [NPORTS-1:0]        hit_sel
);

  logic [NPORTS-1:0] eq;
  logic [31:0]       eq_w;
  logic [31:0]       pick;

  for (genvar i = 0; i < NPORTS; i++) begin : g_cmp
    assign eq[i] = (port_addr[i*BYTE_W +: BYTE_W] == addr);
  end

  assign eq_w    = 32'(eq);
  assign pick    = lowest_bit(eq_w);
  assign hit_sel = pick[NPORTS-1:0];

endmodule

// File: rtl/rtr_fifo.sv
module rtr_fifo
  import rtr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  byte_t wdata,
  input  logic  rd,
  output byte_t rdata,
  output logic  empty,
  output logic  full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = wr & ~full;
  assign do_rd = rd & ~empty;
  assign rdata = mem[rptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= ptr_next(wptr);
      if (do_rd) rptr <= ptr_next(rptr);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
  import rtr_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  byte_t             in_data,
  input  logic [NPORTS-1:0] hit_sel,
  input  logic [NPORTS-1:0] full,
  output logic              suspend,
  output logic              err,
  output logic              acc,
  output logic              drop_hdr,
  output logic [NPORTS-1:0] wr_en
);

  rtr_state_e        state;
  logic [NPORTS-1:0] tgt;
  logic [NPORTS-1:0] tgt_now;
  byte_t             par;
  logic [LEN_W-1:0]  rem;
  logic [LEN_W-1:0]  len_f;

  assign len_f    = in_data[LEN_W-1:0];
  assign tgt_now  = (state == ST_ADDR) ? hit_sel : tgt;
  assign suspend  = |(tgt_now & full);
  assign acc      = in_valid & ~suspend;
  assign wr_en    = acc ? tgt_now : '0;
  assign drop_hdr = acc && (state == ST_ADDR) && (hit_sel == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ADDR;
      tgt   <= '0;
      par   <= '0;
      rem   <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      if (acc) begin
        case (state)
          ST_ADDR: begin
            tgt   <= hit_sel;
            par   <= in_data;
            state <= ST_LEN;
          end
          ST_LEN: begin
            par   <= chk_fold(par, in_data);
            rem   <= len_f;
            state <= (len_f == '0) ? ST_CHK : ST_BODY;
          end
          ST_BODY: begin
            par <= chk_fold(par, in_data);
            rem <= rem - LEN_W'(1);
            if (rem == LEN_W'(1)) state <= ST_CHK;
          end
          default: begin
            err   <= (in_data != par);
            state <= ST_ADDR;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import rtr_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_data,
  input  logic [NPORTS*BYTE_W-1:0] port_addr,
  output logic                    suspend,
  output logic                    err,
  input  logic [NPORTS-1:0]       rd_en,
  output logic [NPORTS-1:0]       out_valid,
  output logic [NPORTS*BYTE_W-1:0] out_data
);

  logic [NPORTS-1:0] hit_sel;
  logic [NPORTS-1:0] full_v;
  logic [NPORTS-1:0] empty_v;
  logic [NPORTS-1:0] wr_en;
  logic              acc;
  logic              drop_hdr;

  rtr_addr_match #(.NPORTS(NPORTS)) u_match (
    .addr     (in_data),
    .port_addr(port_addr),
    .hit_sel  (hit_sel)
  );

  rtr_ctrl #(.NPORTS(NPORTS), .LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_data (in_data),
    .hit_sel (hit_sel),
    .full    (full_v),
    .suspend (suspend),
    .err     (err),
    .acc     (acc),
    .drop_hdr(drop_hdr),
    .wr_en   (wr_en)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    rtr_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_en[i]),
      .wdata(in_data),
      .rd   (rd_en[i]),
      .rdata(out_data[i*BYTE_W +: BYTE_W]),
      .empty(empty_v[i]),
      .full (full_v[i])
    );
  end

  assign out_valid = ~empty_v;

endmodule

// File: rtl/rtr_checker.sv
module rtr_checker #(
  parameter int NPORTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                suspend,
  input logic                err,
  input logic                acc,
  input logic                drop_hdr,
  input logic [NPORTS-1:0]   wr_en,
  input logic [NPORTS-1:0]   full_v,
  input logic [NPORTS-1:0]   rd_en,
  input logic [NPORTS-1:0]   out_valid,
  input logic [NPORTS*8-1:0] out_data
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en & full_v) == '0); // R7

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && suspend) |-> (wr_en == '0 && !acc)); // R7

  AST_MISS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    drop_hdr |-> (wr_en == '0)); // R4

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R6

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[i] && !rd_en[i]) |=> out_valid[i]); // R8

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[i] && !rd_en[i]) |=> $stable(out_data[i*8 +: 8])); // R2

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid[i] && !wr_en[i]) |=> !out_valid[i]); // R8
  end

endmodule

bind pkt_router rtr_checker #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .suspend  (suspend),
  .err      (err),
  .acc      (acc),
  .drop_hdr (drop_hdr),
  .wr_en    (wr_en),
  .full_v   (full_v),
  .rd_en    (rd_en),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_pkt_router.sv
`timescale 1ns/1ps
module test_pkt_router;

  localparam int NP    = 4;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic [NP*8-1:0] port_addr = {8'h40, 8'h30, 8'h20, 8'h10};
  logic          suspend, err;
  logic [NP-1:0] rd_en = '0;
  logic [NP-1:0] out_valid;
  logic [NP*8-1:0] out_data;

  always #2 clk = ~clk;

  pkt_router #(.NPORTS(NP), .DEPTH(DEPTH), .LEN_W(6)) i_pkt_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .port_addr(port_addr), .suspend(suspend), .err(err), .rd_en(rd_en),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] mq [NP][$];
  int         m_st = 0;     // 0 address, 1 length, 2 payload, 3 check
  int         m_tgt = -1;
  logic [7:0] m_par = 8'h00;
  int         m_rem = 0;
  bit         m_err = 0;
  bit         last_acc = 0;

  function automatic int find_port(input logic [7:0] a);
    for (int p = 0; p < NP; p++)
      if (port_addr[p*8 +: 8] == a) return p;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (scenario %s) act=%h exp=%h", what, cur_req, act, exp);
    end
  endtask

  task automatic compare_outs();
    for (int p = 0; p < NP; p++) begin
      bit ev = (mq[p].size() > 0);
      chk(out_valid[p] === ev, $sformatf("R8 R3 out_valid port%0d", p), 32'(out_valid[p]), 32'(ev));
      if (ev) chk(out_data[p*8 +: 8] === mq[p][0], $sformatf("R2 out_data port%0d", p),
                  32'(out_data[p*8 +: 8]), 32'(mq[p][0]));
    end
    chk(err === m_err, "R6 err", 32'(err), 32'(m_err));
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input logic [NP-1:0] rd);
    int  t;
    bit  es, a;
    in_valid = v; in_data = d; rd_en = rd;
    #1;
    t  = (m_st == 0) ? find_port(d) : m_tgt;
    es = (t >= 0) && (mq[t].size() == DEPTH);
    chk(suspend === es, "R7 suspend", 32'(suspend), 32'(es));
    a = v && !es;
    last_acc = a;
    for (int p = 0; p < NP; p++)
      if (rd[p] && mq[p].size() > 0) void'(mq[p].pop_front());
    m_err = 0;
    if (a) begin
      if (t >= 0) mq[t].push_back(d);
      case (m_st)
        0: begin m_tgt = t; m_par = d; m_st = 1; end
        1: begin m_par ^= d; m_rem = int'(d[5:0]); m_st = (m_rem == 0) ? 3 : 2; end
        2: begin m_par ^= d; m_rem--; if (m_rem == 0) m_st = 3; end
        default: begin m_err = (d != m_par); m_st = 0; end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare_outs();
  endtask

  task automatic send_byte(input logic [7:0] d);
    int tries = 0;
    do begin
      cyc(1'b1, d, (tries >= 3) ? {NP{1'b1}} : '0);
      tries++;
    end while (!last_acc);
  endtask

  task automatic send_pkt(input logic [7:0] a, input logic [7:0] lb, input int seed, input bit corrupt);
    logic [7:0] c;
    c = a ^ lb;
    send_byte(a);
    send_byte(lb);
    for (int i = 0; i < int'(lb[5:0]); i++) begin
      logic [7:0] b;
      b = 8'(seed + 7 * i);
      c ^= b;
      send_byte(b);
    end
    send_byte(corrupt ? ~c : c);
  endtask

  task automatic idle(input int n, input logic [NP-1:0] rd);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk(out_valid === '0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(err === 1'b0, "R1 err after reset", 32'(err), 0);
    chk(suspend === 1'b0, "R1 suspend after reset", 32'(suspend), 0);
    idle(2, '0);

    cur_req = "R2";   // R2/R3: routed packet, held then drained
    send_pkt(8'h10, 8'd3, 5, 1'b0);
    idle(2, '0);
    idle(7, 4'b0001);

    cur_req = "R6";   // R6: corrupted check byte
    send_pkt(8'h30, 8'd2, 9, 1'b1);
    idle(6, 4'b0100);

    cur_req = "R4";   // R4: unmatched address dropped, next packet framed correctly
    send_pkt(8'h77, 8'd4, 3, 1'b0);
    send_pkt(8'h40, 8'd1, 1, 1'b0);
    idle(5, 4'b1000);

    cur_req = "R5";   // R5: upper length bits masked
    send_pkt(8'h20, 8'hC2, 11, 1'b0);
    idle(6, 4'b0010);

    cur_req = "R10";  // R10: zero payload
    send_pkt(8'h40, 8'h00, 0, 1'b0);
    send_pkt(8'h40, 8'h80, 0, 1'b1);
    idle(6, 4'b1000);

    cur_req = "R7";   // R7: fill port 1, then a header aimed at a full port, then a long packet
    send_pkt(8'h20, 8'd5, 20, 1'b0);
    idle(2, '0);
    send_pkt(8'h20, 8'd10, 40, 1'b0);
    idle(20, 4'b0010);

    cur_req = "R9";   // R9: duplicate address, lowest index wins
    port_addr[3*8 +: 8] = 8'h20;
    send_pkt(8'h20, 8'd2, 60, 1'b0);
    idle(6, 4'b0010);
    port_addr[3*8 +: 8] = 8'h40;

    cur_req = "R8";   // R8: read-enable on empty ports
    idle(3, {NP{1'b1}});
    send_pkt(8'h10, 8'd1, 70, 1'b0);
    idle(2, 4'b0001);
    idle(6, {NP{1'b1}});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (scenario %s) act=%h exp=%h", cur_req, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule